// File: doc/BRIEF.md
# Security-Banked Interrupt and Reset Control Register

This block is the 32-bit application interrupt and reset control word of a processor interrupt controller whose security extension is optional. It sits behind a plain valid/write/address/data port. Every access carries a security attribute. Writes take effect only when they carry a fixed key in the upper half of the data. A keyed write updates the priority-group field of the accessing security state. It can also request a system reset and, when secure, update three secure-only configuration bits.

The block drives a one-cycle system reset request pulse and a one-cycle guest-error flag. It also drives a group-priority mask derived from the non-secure priority group. A parameter selects whether the security extension exists. Without it, every access is treated as non-secure, and the secure-only bits are constants.

Top module: `sec_bank_ctl_reg`

## Requirements
- R1: A write whose data bits 31:16 differ from 0x05FA changes no state and produces neither a reset request pulse nor an error flag.
- R2: A read at the register address returns 0xFA05 in bits 31:16 and the accessing state's priority group in bits 10:8. Bits 15, 12:11, 7:4 and 2:0 read zero.
- R3: The 3-bit priority group has a secure copy and a non-secure copy, both reset to zero. A keyed write loads bits 10:8 into the copy of its own security state only.
- R4: A keyed write with bit 2 set raises `sys_rst_req` for exactly the following clock. This happens when the access is secure, or when it is non-secure and the stored reset-secure-only bit (bit 3) is clear. In every other case no pulse is produced.
- R5: The stored secure-only bits are reset-secure-only (bit 3), non-secure fault visibility (bit 13) and secure priority boost (bit 14). They change only on keyed secure writes. Non-secure keyed writes leave them unchanged.
- R6: Secure reads return bits 3, 13 and 14 as stored. Non-secure reads return bit 13 as stored and return 0 in bits 3 and 14.
- R7: With the extension present, bits 3, 13 and 14 reset to zero. With it absent, the security attribute is ignored and every access uses the non-secure copy. In that case bit 13 reads one, bits 3 and 14 read zero, and reset requests are never blocked.
- R8: `gprio_mask` equals all-ones of MASK_W bits shifted left by (non-secure priority group + 1). It follows a keyed write from the next clock.
- R9: A keyed write with bit 0 or bit 1 set raises `dbg_err` for exactly the following clock and has no other effect from those bits.
- R10: Reads, and writes to any other address, change no state and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | Security attribute of the access |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, zero when no read hits |
| sys_rst_req | output | 1 | One-cycle system reset request |
| dbg_err | output | 1 | One-cycle guest-error flag |
| gprio_mask | output | MASK_W | Group-priority mask from the non-secure group |

## Verification
The bench builds two instances side by side with MASK_W of 8 and the default address. One has the security extension enabled and the other has it disabled. The enabled instance makes the full cross of security attribute, stored reset-secure-only bit and priority-group value reachable, along with all eight combinations of the secure-only bits. The disabled instance shows that the attribute is ignored, that bit 13 is stuck at one and that reset requests cannot be blocked. Because the group field is only three bits wide, all its values are swept in both banks, and the mask reaches the all-zero case.

// File: rtl/sbcr_pkg.sv
package sbcr_pkg;

    // Key values in bits 31:16
    localparam logic [15:0] WR_KEY = 16'h05FA;
    localparam logic [15:0] RD_SIG = 16'hFA05;

    // Field positions within the control word
    localparam int B_VRST   = 0;
    localparam int B_VCLR   = 1;
    localparam int B_RSTREQ = 2;
    localparam int B_RSTSEC = 3;
    localparam int PG_LO    = 8;
    localparam int PG_HI    = 10;
    localparam int B_NMINS  = 13;
    localparam int B_PRIS   = 14;
    localparam int KEY_LO   = 16;

    localparam int PG_W    = PG_HI - PG_LO + 1;
    localparam int NBANK   = 2;
    localparam int BANK_NS = 0;
    localparam int BANK_S  = 1;

    typedef logic [PG_W-1:0] pg_t;

    typedef struct packed {
        logic rst_sec_only;
        logic nmi_ns;
        logic prio_s;
    } seccfg_t;

    typedef struct packed {
        logic    keyed;
        logic    secure;
        pg_t     pg;
        logic    rst_req;
        logic    dbg_err;
        seccfg_t cfg;
    } wr_cmd_t;

    typedef struct packed {
        logic hit;
        logic secure;
    } rd_cmd_t;

    // Constant secure-only bits when the extension is absent
    localparam seccfg_t CFG_NOEXT = '{rst_sec_only: 1'b0, nmi_ns: 1'b1, prio_s: 1'b0};
    localparam seccfg_t CFG_RESET = '{rst_sec_only: 1'b0, nmi_ns: 1'b0, prio_s: 1'b0};

    // Word seen by a read of the given security state
    function automatic logic [31:0] view_word(pg_t pg, seccfg_t cfg, logic secure);
        logic [31:0] w;
        w = '0;
        w[KEY_LO +: 16]  = RD_SIG;
        w[PG_HI:PG_LO]   = pg;
        w[B_NMINS]       = cfg.nmi_ns;
        if (secure) begin
            w[B_RSTSEC] = cfg.rst_sec_only;
            w[B_PRIS]   = cfg.prio_s;
        end
        return w;
    endfunction

endpackage

// File: rtl/sbcr_decode.sv
module sbcr_decode
    import sbcr_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'hD0C,
    parameter bit                SEC_EXT  = 1'b1
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_secure,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    output wr_cmd_t           wr_cmd,
    output rd_cmd_t           rd_cmd
);

    logic hit;
    logic sec_eff;
    logic unused_wdata;

    assign hit          = acc_valid && (acc_addr == REG_ADDR);
    assign sec_eff      = acc_secure & SEC_EXT;
    assign unused_wdata = ^{acc_wdata[15], acc_wdata[12:11], acc_wdata[7:4]};

    always_comb begin
        wr_cmd                  = '0;
        wr_cmd.keyed            = hit && acc_write && (acc_wdata[KEY_LO +: 16] == WR_KEY);
        wr_cmd.secure           = sec_eff;
        wr_cmd.pg               = acc_wdata[PG_HI:PG_LO];
        wr_cmd.rst_req          = acc_wdata[B_RSTREQ];
        wr_cmd.dbg_err          = acc_wdata[B_VCLR] | acc_wdata[B_VRST];
        wr_cmd.cfg.rst_sec_only = acc_wdata[B_RSTSEC];
        wr_cmd.cfg.nmi_ns       = acc_wdata[B_NMINS];
        wr_cmd.cfg.prio_s       = acc_wdata[B_PRIS];
    end

    always_comb begin
        rd_cmd        = '0;
        rd_cmd.hit    = hit && !acc_write;
        rd_cmd.secure = sec_eff;
    end

endmodule

// File: rtl/sbcr_bank_store.sv
module sbcr_bank_store
    import sbcr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic keyed,
    input  logic secure,
    input  pg_t  pg_in,
    output pg_t  pg_s,
    output pg_t  pg_ns
);

    pg_t pg_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam bit IS_S = (b == BANK_S);
        pg_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (keyed && (secure == IS_S)) begin
                q <= pg_in;
            end
        end
        assign pg_q[b] = q;
    end

    assign pg_s  = pg_q[BANK_S];
    assign pg_ns = pg_q[BANK_NS];

endmodule

// File: rtl/sbcr_sec_cfg.sv
module sbcr_sec_cfg
    import sbcr_pkg::*;
#(
    parameter bit SEC_EXT = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    keyed,
    input  logic    secure,
    input  seccfg_t cfg_in,
    output seccfg_t cfg
);

    seccfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (keyed && secure) begin
            cfg_q <= cfg_in;
        end
    end

    always_comb begin
        cfg = SEC_EXT ? cfg_q : CFG_NOEXT;
    end

endmodule

// File: rtl/sbcr_pulse_gen.sv
module sbcr_pulse_gen (
    input  logic clk,
    input  logic rst,
    input  logic keyed,
    input  logic secure,
    input  logic rst_req,
    input  logic err_req,
    input  logic rst_sec_only,
    output logic sys_rst_req,
    output logic dbg_err
);

    logic allow;

    assign allow = secure || !rst_sec_only;

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_rst_req <= 1'b0;
            dbg_err     <= 1'b0;
        end else begin
            sys_rst_req <= keyed && rst_req && allow;
            dbg_err     <= keyed && err_req;
        end
    end

endmodule

// File: rtl/sec_bank_ctl_reg.sv
module sec_bank_ctl_reg
    import sbcr_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'hD0C,
    parameter bit                SEC_EXT  = 1'b1,
    parameter int                MASK_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_secure,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       rd_data,
    output logic              sys_rst_req,
    output logic              dbg_err,
    output logic [MASK_W-1:0] gprio_mask
);

    localparam int SH_W = PG_W + 1;

    wr_cmd_t wr_cmd;
    rd_cmd_t rd_cmd;
    pg_t     pg_s;
    pg_t     pg_ns;
    seccfg_t cfg;
    logic    rst_sec_only;
    logic [SH_W-1:0] shamt;

    sbcr_decode #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR),
        .SEC_EXT  (SEC_EXT)
    ) u_decode (
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_secure (acc_secure),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .wr_cmd     (wr_cmd),
        .rd_cmd     (rd_cmd)
    );

    sbcr_bank_store u_banks (
        .clk    (clk),
        .rst    (rst),
        .keyed  (wr_cmd.keyed),
        .secure (wr_cmd.secure),
        .pg_in  (wr_cmd.pg),
        .pg_s   (pg_s),
        .pg_ns  (pg_ns)
    );

    sbcr_sec_cfg #(
        .SEC_EXT (SEC_EXT)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .keyed  (wr_cmd.keyed),
        .secure (wr_cmd.secure),
        .cfg_in (wr_cmd.cfg),
        .cfg    (cfg)
    );

    assign rst_sec_only = cfg.rst_sec_only;

    sbcr_pulse_gen u_pulse (
        .clk          (clk),
        .rst          (rst),
        .keyed        (wr_cmd.keyed),
        .secure       (wr_cmd.secure),
        .rst_req      (wr_cmd.rst_req),
        .err_req      (wr_cmd.dbg_err),
        .rst_sec_only (rst_sec_only),
        .sys_rst_req  (sys_rst_req),
        .dbg_err      (dbg_err)
    );

    // Read view: the accessing state's bank and visibility
    always_comb begin
        if (rd_cmd.hit) begin
            rd_data = view_word(rd_cmd.secure ? pg_s : pg_ns, cfg, rd_cmd.secure);
        end else begin
            rd_data = '0;
        end
    end

    // Group-priority mask from the non-secure bank
    assign shamt      = {1'b0, pg_ns} + SH_W'(1);
    assign gprio_mask = {MASK_W{1'b1}} << shamt;

endmodule

// File: rtl/sbcr_checker.sv
module sbcr_checker #(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'hD0C,
    parameter bit                SEC_EXT  = 1'b1,
    parameter int                MASK_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic              acc_secure,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [31:0]       acc_wdata,
    input logic [31:0]       rd_data,
    input logic              sys_rst_req,
    input logic              dbg_err,
    input logic [MASK_W-1:0] gprio_mask,
    input logic              rst_sec_only
);

    logic at_reg, kw, rd_hit, sec_a, unused_chk;

    assign at_reg     = acc_valid && (acc_addr == REG_ADDR);
    assign kw         = at_reg && acc_write && (acc_wdata[31:16] == 16'h05FA);
    assign rd_hit     = at_reg && !acc_write;
    assign sec_a      = acc_secure & SEC_EXT;
    assign unused_chk = ^{acc_wdata[15:3], rd_data[15], rd_data[12:4], rd_data[2:0]};

    p_key_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_wdata[31:16] != 16'h05FA)
        |=> (!sys_rst_req && !dbg_err && $stable(gprio_mask)));

    p_read_sig_r2: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> (rd_data[31:16] == 16'hFA05));

    p_req_source_r4: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> $past(kw && acc_wdata[2]));

    p_ns_block_r4: assert property (@(posedge clk) disable iff (rst)
        (kw && !sec_a && acc_wdata[2] && rst_sec_only) |=> !sys_rst_req);

    p_ns_hide_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && !sec_a) |-> (!rd_data[3] && !rd_data[14]));

    p_noext_bit_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && !SEC_EXT) |-> rd_data[13]);

    p_err_source_r9: assert property (@(posedge clk) disable iff (rst)
        dbg_err |-> $past(kw && (acc_wdata[1:0] != 2'b00)));

    p_read_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write) |=> (!sys_rst_req && !dbg_err && $stable(gprio_mask)));

endmodule

bind sec_bank_ctl_reg sbcr_checker #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .SEC_EXT  (SEC_EXT),
    .MASK_W   (MASK_W)
) u_chk (.*);

// File: tb/test_sec_bank_ctl_reg.sv
module test_sec_bank_ctl_reg;

    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 12;
    localparam logic [11:0] REG        = 12'hD0C;
    localparam int          MASK_W     = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic        v  [2];
    logic        w  [2];
    logic        s  [2];
    logic [11:0] a  [2];
    logic [31:0] wd [2];
    logic [31:0] rd [2];
    logic        rq [2];
    logic        er [2];
    logic [7:0]  mk [2];

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model, updated from the requirements
    int   mpg_s  [2];
    int   mpg_ns [2];
    logic m_rs   [2];
    logic m_nm   [2];
    logic m_pr   [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_bank_ctl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG), .SEC_EXT(1'b1), .MASK_W(MASK_W)) i_sec_bank_ctl_reg (
        .clk(clk), .rst(rst), .acc_valid(v[0]), .acc_write(w[0]), .acc_secure(s[0]),
        .acc_addr(a[0]), .acc_wdata(wd[0]), .rd_data(rd[0]), .sys_rst_req(rq[0]),
        .dbg_err(er[0]), .gprio_mask(mk[0]));

    sec_bank_ctl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG), .SEC_EXT(1'b0), .MASK_W(MASK_W)) i_sec_bank_ctl_reg_nx (
        .clk(clk), .rst(rst), .acc_valid(v[1]), .acc_write(w[1]), .acc_secure(s[1]),
        .acc_addr(a[1]), .acc_wdata(wd[1]), .rd_data(rd[1]), .sys_rst_req(rq[1]),
        .dbg_err(er[1]), .gprio_mask(mk[1]));

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(int d, bit sec);
        logic [31:0] e;
        bit es;
        es = sec && (d == 0);
        e = '0;
        e[31:16] = 16'hFA05;
        e[10:8]  = 3'(es ? mpg_s[d] : mpg_ns[d]);
        e[13]    = (d == 0) ? m_nm[d] : 1'b1;
        if (es) begin
            e[3]  = m_rs[d];
            e[14] = m_pr[d];
        end
        return e;
    endfunction

    function automatic logic [7:0] exp_mask(int d);
        logic [8:0] t;
        t = 9'h0FF << (mpg_ns[d] + 1);
        return t[7:0];
    endfunction

    // Read both views and the mask of one instance; reads must be quiet
    task automatic rdchk(int d, string tag);
        for (int sc = 0; sc < 2; sc++) begin
            @(negedge clk);
            v[d] = 1'b1; w[d] = 1'b0; s[d] = sc[0]; a[d] = REG; wd[d] = 32'h05FA_0004;
            #1;
            chk($sformatf("%s read d=%0d sec=%0d", tag, d, sc), rd[d], exp_read(d, sc[0]));
            @(negedge clk);
            v[d] = 1'b0;
            chk($sformatf("R10 read no pulse d=%0d", d), {30'b0, rq[d], er[d]}, 32'h0);
        end
        chk($sformatf("R8 mask d=%0d", d), {24'b0, mk[d]}, {24'b0, exp_mask(d)});
    endtask

    task automatic wr(int d, bit sec, logic [11:0] addr, logic [31:0] data, string tag);
        bit keyed, es, exp_rq, exp_er;
        logic got_rq, got_er;
        keyed  = (addr == REG) && (data[31:16] == 16'h05FA);
        es     = sec && (d == 0);
        exp_rq = keyed && data[2] && (es || !((d == 0) ? m_rs[d] : 1'b0));
        exp_er = keyed && (data[1:0] != 2'b00);
        @(negedge clk);
        v[d] = 1'b1; w[d] = 1'b1; s[d] = sec; a[d] = addr; wd[d] = data;
        @(negedge clk);
        v[d] = 1'b0; w[d] = 1'b0;
        got_rq = rq[d]; got_er = er[d];
        chk($sformatf("%s R4 pulse d=%0d", tag, d), {31'b0, got_rq}, {31'b0, exp_rq});
        chk($sformatf("%s R9 err d=%0d", tag, d), {31'b0, got_er}, {31'b0, exp_er});
        @(negedge clk);
        chk($sformatf("%s R4 R9 single cycle d=%0d", tag, d), {30'b0, rq[d], er[d]}, 32'h0);
        if (keyed) begin
            if (es) mpg_s[d] = int'(data[10:8]);
            else    mpg_ns[d] = int'(data[10:8]);
            if (es) begin
                m_rs[d] = data[3];
                m_nm[d] = data[13];
                m_pr[d] = data[14];
            end
        end
    endtask

    function automatic logic [31:0] mkw(logic [15:0] key, int pg, logic b14, logic b13, logic b3, logic [2:0] low);
        logic [31:0] x;
        x = '0;
        x[31:16] = key;
        x[10:8]  = 3'(pg);
        x[14]    = b14;
        x[13]    = b13;
        x[3]     = b3;
        x[2:0]   = low;
        return x;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            v[d] = 0; w[d] = 0; s[d] = 0; a[d] = '0; wd[d] = '0;
            mpg_s[d] = 0; mpg_ns[d] = 0; m_rs[d] = 0; m_nm[d] = 0; m_pr[d] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7 R2 reset state, both instances
        for (int d = 0; d < 2; d++) rdchk(d, "R7 R2 reset");
        chk("R7 reset word secure ext", 32'hFA05_0000, exp_read(0, 1));

        // R3 R8 bank sweep
        for (int d = 0; d < 2; d++)
            for (int sc = 0; sc < 2; sc++)
                for (int pg = 0; pg < 8; pg++) begin
                    wr(d, sc[0], REG, mkw(16'h05FA, pg, 1'b0, (d == 0) ? m_nm[d] : 1'b0, 1'b0, 3'b000), "R3 bank");
                    rdchk(d, "R3 R2 bank");
                end

        // R1 bad keys
        for (int d = 0; d < 2; d++)
            for (int k = 0; k < 4; k++) begin
                logic [15:0] key;
                key = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFA05 : (k == 2) ? 16'h05FB : 16'hFFFF;
                wr(d, 1'b1, REG, mkw(key, 6, 1'b1, 1'b1, 1'b1, 3'b111), "R1 badkey");
                wr(d, 1'b0, REG, mkw(key, 2, 1'b1, 1'b1, 1'b1, 3'b111), "R1 badkey");
                rdchk(d, "R1 after badkey");
            end

        // R10 wrong address
        wr(0, 1'b1, REG + 12'd4, mkw(16'h05FA, 5, 1'b1, 1'b1, 1'b1, 3'b111), "R10 wrong addr");
        rdchk(0, "R10 after wrong addr");

        // R5 R6 secure-only bits on the extension instance
        for (int c = 0; c < 8; c++) begin
            wr(0, 1'b1, REG, mkw(16'h05FA, mpg_s[0], c[2], c[1], c[0], 3'b000), "R5 secure cfg");
            rdchk(0, "R6 view");
            wr(0, 1'b0, REG, mkw(16'h05FA, mpg_ns[0], ~c[2], ~c[1], ~c[0], 3'b000), "R5 ns cfg");
            rdchk(0, "R5 ns unchanged");
        end

        // R4 reset request matrix
        for (int rs = 0; rs < 2; rs++) begin
            wr(0, 1'b1, REG, mkw(16'h05FA, mpg_s[0], 1'b0, 1'b0, rs[0], 3'b000), "R4 setup");
            wr(0, 1'b1, REG, mkw(16'h05FA, mpg_s[0], 1'b0, 1'b0, rs[0], 3'b100), "R4 secure req");
            wr(0, 1'b0, REG, mkw(16'h05FA, mpg_ns[0], 1'b0, 1'b0, 1'b0, 3'b100), "R4 ns req");
        end
        // R7 no blocking without the extension
        wr(1, 1'b1, REG, mkw(16'h05FA, 5, 1'b1, 1'b0, 1'b1, 3'b000), "R7 noext cfg");
        rdchk(1, "R7 noext view");
        wr(1, 1'b0, REG, mkw(16'h05FA, 5, 1'b0, 1'b0, 1'b1, 3'b100), "R7 noext ns req");
        wr(1, 1'b1, REG, mkw(16'h05FA, 1, 1'b0, 1'b0, 1'b1, 3'b100), "R7 noext sec req");
        rdchk(1, "R7 noext bank");

        // R9 error flag sweep
        for (int d = 0; d < 2; d++)
            for (int e = 0; e < 4; e++) begin
                wr(d, 1'b0, REG, mkw(16'h05FA, mpg_ns[d], 1'b0, 1'b0, 1'b0, {1'b0, e[1:0]}), "R9 err");
                rdchk(d, "R9 state");
            end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule